// File: doc/BRIEF.md
# I2C Serial Clock Divider with Duty-Cycle Control

This block turns a fast source clock into the serial clock waveform of an I2C controller. One packed control word sets the timing: an 8-bit low-time divider in bits 7:0, a high-time divider in bits 23:16 and a 3-bit high-speed divider in bits 10:8. The block adds a fixed offset of three source clocks to each divider. Each phase therefore lasts its divider value plus three cycles.

When the high-time field is zero, the high phase copies the low phase. This gives the symmetric 50% waveform used in standard mode, where software sets the main divider to (source/target)/2 − 3. When the field is nonzero it sets the high phase on its own. Fast and fast-plus modes use this for a one-third high, two-thirds low waveform, with the main divider at ((source/target) − 6)·2/3 and the high-time field at half of that. The block serves rates up to 1 MHz.

The block also drives two single-cycle strobes for a bit engine: one in the middle of each low phase, where SDA may change, and one in the middle of each high phase, where SDA is sampled. The high-speed divider field is accepted but does not change the waveform.

Top module: `scl_divider`

## Requirements
- R1: After reset, and until the run input is sampled high, scl_hi_o is 1 and both strobes are 0.
- R2: While run_i is low, scl_hi_o stays 1 and both strobes stay 0, whatever the control word holds.
- R3: The clock edge that first samples run_i high starts a low phase. The low phase lasts ctrl_i[7:0] + 3 cycles, so scl_hi_o is 0 from the cycle after that edge.
- R4: When ctrl_i[23:16] is zero, the high phase lasts as long as the low phase, ctrl_i[7:0] + 3 cycles.
- R5: When ctrl_i[23:16] is nonzero, the high phase lasts ctrl_i[23:16] + 3 cycles, and the low phase still follows R3.
- R6: mid_low_o is 1 for exactly one cycle per low phase. It pulses in the cycle whose 0-based index within the low phase is floor(L/2), where L is the low length.
- R7: mid_high_o is 1 for exactly one cycle per high phase. It pulses in the cycle whose 0-based index within the high phase is floor(H/2), where H is the high length.
- R8: The control word is captured only when a period starts (run sampled high while idle, or the last high cycle ending). A change made mid-period takes effect from the next period.
- R9: Bits 15:8 of the control word have no effect on the waveform or the strobes. This includes the high-speed divider in bits 10:8.
- R10: Dropping run_i ends the waveform at the next clock edge, even in the middle of a phase. From the following cycle R2 holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run_i | input | 1 | Produce the clock waveform while high |
| ctrl_i | input | 24 | Packed timing word: [7:0] low divider, [10:8] high-speed divider, [23:16] high divider |
| scl_hi_o | output | 1 | 1 while the serial clock is released high, 0 while it is driven low |
| mid_low_o | output | 1 | Single-cycle strobe in the middle of the low phase |
| mid_high_o | output | 1 | Single-cycle strobe in the middle of the high phase |

## Verification
All outputs come from one register stage. When run_i is sampled high at an edge, the first low cycle shows in the cycle that follows that edge. Every later value sits at a fixed offset inside a period of L + H cycles. The bench drives run_i and ctrl_i on the falling edge, samples every output on the next falling edge and counts cycles from there. Its expected waveform comes from a position counter of its own, and a control change is timed to land inside the first period. Stopping is checked one cycle after the falling edge that drops run_i.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
  // Phase of the generated serial clock
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_e;
endpackage

// File: rtl/scl_div_decode.sv
// Turns the packed control word into phase lengths in source clocks.
module scl_div_decode #(
  parameter int CTRL_W = 24,
  parameter int DIV_W  = 8,
  parameter int HI_LSB = 16,
  parameter int OFFSET = 3,
  localparam int CNT_W = DIV_W + 1
) (
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic [CNT_W-1:0]  lo_len_o,
  output logic [CNT_W-1:0]  hi_len_o
);
  logic [DIV_W-1:0] lo_div;
  logic [DIV_W-1:0] hi_div;

  always_comb begin
    lo_div   = ctrl_i[DIV_W-1:0];
    hi_div   = ctrl_i[HI_LSB +: DIV_W];
    lo_len_o = {1'b0, lo_div} + CNT_W'(OFFSET);
    if (hi_div == '0) begin
      hi_len_o = lo_len_o;
    end else begin
      hi_len_o = {1'b0, hi_div} + CNT_W'(OFFSET);
    end
  end
endmodule

// File: rtl/scl_div_timer.sv
// Phase sequencer: counts the low and high phases and marks their midpoints.
module scl_div_timer
  import scl_div_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] lo_len_i,
  input  logic [CNT_W-1:0] hi_len_i,
  output logic             scl_hi_o,
  output logic             mid_low_o,
  output logic             mid_high_o
);
  scl_phase_e       phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] lo_len_q, hi_len_q;
  logic             load_en;
  logic             lo_last, hi_last;

  always_comb begin
    lo_last = (cnt_q == lo_len_q - CNT_W'(1));
    hi_last = (cnt_q == hi_len_q - CNT_W'(1));
    phase_d = phase_q;
    cnt_d   = cnt_q;
    load_en = 1'b0;
    if (!run_i) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          phase_d = PH_LOW;
          cnt_d   = '0;
          load_en = 1'b1;
        end
        PH_LOW: begin
          if (lo_last) begin
            phase_d = PH_HIGH;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        PH_HIGH: begin
          if (hi_last) begin
            phase_d = PH_LOW;
            cnt_d   = '0;
            load_en = 1'b1;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        default: begin
          phase_d = PH_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  // Timing is captured only at a period boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_len_q <= '0;
      hi_len_q <= '0;
    end else if (load_en) begin
      lo_len_q <= lo_len_i;
      hi_len_q <= hi_len_i;
    end
  end

  always_comb begin
    scl_hi_o   = (phase_q != PH_LOW);
    mid_low_o  = (phase_q == PH_LOW)  && (cnt_q == (lo_len_q >> 1));
    mid_high_o = (phase_q == PH_HIGH) && (cnt_q == (hi_len_q >> 1));
  end
endmodule

// File: rtl/scl_divider.sv
module scl_divider #(
  parameter int CTRL_W = 24,
  parameter int DIV_W  = 8,
  parameter int HI_LSB = 16,
  parameter int OFFSET = 3,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W = DIV_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic              scl_hi_o,
  output logic              mid_low_o,
  output logic              mid_high_o
);
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;
  logic [CNT_W-1:0]       lo_len, hi_len;

  // Reset asserts asynchronously and is released on the clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  scl_div_decode #(
    .CTRL_W (CTRL_W),
    .DIV_W  (DIV_W),
    .HI_LSB (HI_LSB),
    .OFFSET (OFFSET)
  ) u_decode (
    .ctrl_i   (ctrl_i),
    .lo_len_o (lo_len),
    .hi_len_o (hi_len)
  );

  scl_div_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_int_n),
    .run_i      (run_i),
    .lo_len_i   (lo_len),
    .hi_len_i   (hi_len),
    .scl_hi_o   (scl_hi_o),
    .mid_low_o  (mid_low_o),
    .mid_high_o (mid_high_o)
  );
endmodule

// File: rtl/scl_divider_checker.sv
module scl_divider_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic run_i,
  input logic scl_hi_o,
  input logic mid_low_o,
  input logic mid_high_o
);
  // R2 R10: no run, no waveform on the next cycle
  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (scl_hi_o && !mid_low_o && !mid_high_o));

  // R3: a rising run starts with a low phase
  p_start_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_i) |=> !scl_hi_o);

  // R3: a low phase lasts at least the fixed offset
  p_low_min_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(scl_hi_o) && run_i) |=> !scl_hi_o);

  // R6: the mid-low strobe lives inside the low phase and is one cycle wide
  p_mid_low_in_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mid_low_o |-> !scl_hi_o);
  p_mid_low_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mid_low_o |=> !mid_low_o);

  // R7: the mid-high strobe lives inside the high phase and is one cycle wide
  p_mid_high_in_high_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mid_high_o |-> scl_hi_o);
  p_mid_high_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mid_high_o |=> !mid_high_o);
endmodule

bind scl_divider scl_divider_checker u_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .run_i      (run_i),
  .scl_hi_o   (scl_hi_o),
  .mid_low_o  (mid_low_o),
  .mid_high_o (mid_high_o)
);

// File: tb/scl_divider_test.sv
module scl_divider_test;
  localparam int PERIOD_NS = 8;

  logic        clk;
  logic        rst_n;
  logic        run;
  logic [23:0] ctrl;
  logic        scl_hi, mid_low, mid_high;

  int n_vec = 0;
  int n_err = 0;
  bit done  = 0;

  scl_divider uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .run_i      (run),
    .ctrl_i     (ctrl),
    .scl_hi_o   (scl_hi),
    .mid_low_o  (mid_low),
    .mid_high_o (mid_high)
  );

  initial clk = 1'b0;
  always #(PERIOD_NS/2) clk = ~clk;

  function automatic int low_len(input logic [23:0] c);
    return int'(c[7:0]) + 3;
  endfunction

  function automatic int high_len(input logic [23:0] c);
    return (c[23:16] == 8'd0) ? int'(c[7:0]) + 3 : int'(c[23:16]) + 3;
  endfunction

  task automatic check3(input string req, input logic s, input logic ml, input logic mh,
                        input logic es, input logic eml, input logic emh);
    n_vec++;
    if ({s, ml, mh} !== {es, eml, emh}) begin
      n_err++;
      $display("FAIL %s: {scl,mid_low,mid_high} = %b%b%b, expected %b%b%b at %0t",
               req, s, ml, mh, es, eml, emh, $time);
    end
  endtask

  // Run with c1, switch to c2 after sample index chg_at, observe n cycles.
  // R3 R4 R5 R6 R7 R8 share this waveform model.
  task automatic run_wave(input string req, input logic [23:0] c1, input logic [23:0] c2,
                          input int chg_at, input int n);
    int L, H, pos;
    logic [23:0] nxt;
    nxt = c1;
    @(negedge clk);
    ctrl = c1;
    run  = 1'b1;
    L = low_len(c1);
    H = high_len(c1);
    pos = 0;
    for (int t = 0; t < n; t++) begin
      @(negedge clk);
      check3(req, scl_hi, mid_low, mid_high,
             (pos >= L), (pos == L/2), (pos == L + H/2));
      if (t == chg_at) begin
        ctrl = c2;
        nxt  = c2;
      end
      if (pos == L + H - 1) begin
        pos = 0;
        L = low_len(nxt);
        H = high_len(nxt);
      end else begin
        pos++;
      end
    end
    // R10: drop run mid-waveform, idle from next sample
    run = 1'b0;
    for (int t = 0; t < 4; t++) begin
      @(negedge clk);
      check3("R10", scl_hi, mid_low, mid_high, 1'b1, 1'b0, 1'b0);
    end
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    run   = 1'b0;
    ctrl  = 24'h000005;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check3("R1", scl_hi, mid_low, mid_high, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic test_idle();
    run = 1'b0;
    for (int t = 0; t < 6; t++) begin
      @(negedge clk);
      ctrl = 24'h030000 | 24'(t);
      check3("R2", scl_hi, mid_low, mid_high, 1'b1, 1'b0, 1'b0);
    end
  endtask

  initial begin
    #(PERIOD_NS * 200000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    test_reset();
    test_idle();
    run_wave("R4 symmetric", 24'h000005, 24'h000005, -1, 40);
    run_wave("R5 fast duty", 24'h040008, 24'h040008, -1, 60);
    run_wave("R3 minimum", 24'h000000, 24'h000000, -1, 20);
    run_wave("R4 maximum", 24'h0000FF, 24'h0000FF, -1, 1100);
    run_wave("R5 long high", 24'h090002, 24'h090002, -1, 50);
    run_wave("R8 switch", 24'h000006, 24'h020004, 3, 60);
    run_wave("R9 hs field", 24'h04FF08, 24'h04FF08, -1, 60);
    run_wave("R6 R7 odd", 24'h030006, 24'h030006, -1, 45);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule